// File: doc/BRIEF.md
# Signed Carry-Save Multiply-Accumulate Unit

This unit forms `acc + a*b` for an 8-bit signed operand `a`, an 8-bit signed coefficient `b` and a 16-bit accumulator word. It is the arithmetic core of one processing cell in a multiply-accumulate grid.

The product is built by a radix-2 Booth multiplier. A 3:2 carry-save stage then takes three words: the product, the accumulator input and a zero word. A single carry-propagate adder merges the resulting sum vector with the carry vector shifted left by one bit. All arithmetic is two's complement modulo 2^16.

An output register, selected by a parameter, captures the result on a clock edge when the enable is high. It holds its value when the enable is low and clears under an active-low asynchronous reset. With the register left out, the unit is purely combinational.

Top module: `signed_csa_mac`

## Requirements
- R1: With the output register enabled, `res_o` equals `(acc_i + a*b) mod 2^16` one cycle after a rising edge with `en_i` high. `a` is `op_a_i` and `b` is `coef_i`, both read as two's-complement 8-bit values. This holds for all 65536 operand pairs under varied accumulator values.
- R2: The extreme pair -128 × -128 with `acc_i` = 0 gives `res_o` = 16384 (0x4000).
- R3: The internal Booth product equals the signed 16-bit product of the two operands. Bit pair (b[i], b[i-1]) with b[-1]=0 adds +A<<i for 01, adds -A<<i for 10, and adds nothing for 00 and 11.
- R4: The carry-save outputs satisfy `sum + 2*carry == product + acc_i + 0` modulo 2^16.
- R5: Accumulation wraps modulo 2^16. `acc_i`=0x7FFF with 1×1 gives 0x8000, and `acc_i`=0x0000 with -1×1 gives 0xFFFF.
- R6: A new result appears at `res_o` exactly one rising edge after it is presented with `en_i` high, and not before.
- R7: With `en_i` low, `res_o` keeps its previous value across rising edges whatever the inputs do.
- R8: While `rst_ni` is low, `res_o` is 0 at once, without waiting for a clock edge. Reset overrides a simultaneous `en_i` high with nonzero operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| en_i | input | 1 | Synchronous load enable of the output register |
| op_a_i | input | 8 | Signed operand |
| coef_i | input | 8 | Signed coefficient (Booth-recoded side) |
| acc_i | input | 16 | Accumulator input |
| res_o | output | 16 | Accumulated result |

## Verification
The two functions that can meet in one cycle are the enabled load of a fresh result and the asynchronous clear. The bench holds `en_i` high with nonzero operands and drops `rst_ni` between clock edges. It expects `res_o` to read 0 immediately, and to stay 0 across the following rising edge. After `rst_ni` is released away from an edge, the next enabled edge must load the correct sum. This shows that the clear won outright and left no stale state in the register.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // radix-2 recoding of bit pair {b[i], b[i-1]}
  typedef enum logic [1:0] {
    BOOTH_ZERO_LO = 2'b00,
    BOOTH_ADD     = 2'b01,
    BOOTH_SUB     = 2'b10,
    BOOTH_ZERO_HI = 2'b11
  } booth_op_e;
endpackage

// File: rtl/booth_mul.sv
module booth_mul
  import mac_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int P_W = 16
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  localparam int EXT_W = P_W - A_W;

  logic [P_W-1:0] a_ext;
  logic [P_W-1:0] a_neg;
  logic [P_W-1:0] pp [B_W];

  assign a_ext = {{EXT_W{a_i[A_W-1]}}, a_i};
  assign a_neg = ~a_ext + P_W'(1);

  for (genvar i = 0; i < B_W; i++) begin : g_pp
    booth_op_e op;
    if (i == 0) begin : g_first
      assign op = booth_op_e'({b_i[0], 1'b0});
    end else begin : g_rest
      assign op = booth_op_e'({b_i[i], b_i[i-1]});
    end
    always_comb begin
      unique case (op)
        BOOTH_ADD: pp[i] = a_ext << i;
        BOOTH_SUB: pp[i] = a_neg << i;
        default:   pp[i] = '0;
      endcase
    end
  end

  always_comb begin
    p_o = '0;
    for (int k = 0; k < B_W; k++) p_o = p_o + pp[k];
  end
endmodule

// File: rtl/csa32.sv
module csa32 #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  assign sum_o   = x_i ^ y_i ^ z_i;
  assign carry_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
endmodule

// File: rtl/cpa_add.sv
module cpa_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] carry_i,
  output logic [W-1:0] res_o
);
  // carry vector carries weight 2
  assign res_o = sum_i + {carry_i[W-2:0], 1'b0};
endmodule

// File: rtl/signed_csa_mac.sv
module signed_csa_mac #(
  parameter int  A_W     = 8,
  parameter int  B_W     = 8,
  parameter int  ACC_W   = 16,
  parameter bit  OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [A_W-1:0]   op_a_i,
  input  logic [B_W-1:0]   coef_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] res_o
);
  logic [ACC_W-1:0] prod_w;
  logic [ACC_W-1:0] s_w;
  logic [ACC_W-1:0] c_w;
  logic [ACC_W-1:0] mac_w;

  booth_mul #(.A_W(A_W), .B_W(B_W), .P_W(ACC_W)) u_mul (
    .a_i (op_a_i),
    .b_i (coef_i),
    .p_o (prod_w)
  );

  // R3
  booth_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_w == ACC_W'($signed(op_a_i) * $signed(coef_i)));

  csa32 #(.W(ACC_W)) u_csa (
    .x_i     (prod_w),
    .y_i     (acc_i),
    .z_i     ('0),
    .sum_o   (s_w),
    .carry_o (c_w)
  );

  // R4
  csa_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ACC_W'(s_w + (c_w << 1)) == ACC_W'(prod_w + acc_i));

  cpa_add #(.W(ACC_W)) u_cpa (
    .sum_i   (s_w),
    .carry_i (c_w),
    .res_o   (mac_w)
  );

  // R1
  mac_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_w == ACC_W'(acc_i + ACC_W'($signed(op_a_i) * $signed(coef_i))));

  if (OUT_REG) begin : g_reg
    logic [ACC_W-1:0] res_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   res_q <= '0;
      else if (en_i) res_q <= mac_w;
    end
    assign res_o = res_q;

    // R6
    load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> res_o == $past(mac_w));
    // R7
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(res_o));
  end else begin : g_comb
    assign res_o = mac_w;
  end
endmodule

// File: tb/signed_csa_mac_tb.sv
module signed_csa_mac_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [7:0]  op_a_i = '0;
  logic [7:0]  coef_i = '0;
  logic [15:0] acc_i = '0;
  logic [15:0] res_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  signed_csa_mac u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .en_i (en_i),
    .op_a_i (op_a_i), .coef_i (coef_i), .acc_i (acc_i), .res_o (res_o)
  );

  function automatic logic [15:0] exp_mac(logic [7:0] a, logic [7:0] b, logic [15:0] acc);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return acc + p[15:0];
  endfunction

  task automatic chk(logic [15:0] got, logic [15:0] exp, string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at negedge, sample just after the loading edge
  task automatic apply(logic [7:0] a, logic [7:0] b, logic [15:0] acc, string req);
    @(negedge clk);
    op_a_i = a; coef_i = b; acc_i = acc; en_i = 1'b1;
    @(posedge clk); #1;
    chk(res_o, exp_mac(a, b, acc), req);
  endtask

  task automatic t_reset();
    #1; chk(res_o, 16'h0000, "R8 reset state");
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_sweep(int mode);
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] acc;
      acc = (mode == 0) ? (16'(i) ^ 16'h5A3C) : 16'(i * 7 + 16'h8001);
      apply(8'(i >> 8), 8'(i), acc, "R1 sweep");
    end
  endtask

  task automatic t_corners();
    apply(8'h80, 8'h80, 16'h0000, "R2 -128*-128");
    apply(8'h80, 8'h80, 16'hFFFF, "R2 -128*-128 acc -1");
    apply(8'h7F, 8'h80, 16'h0000, "R3 127*-128");
    apply(8'h55, 8'hAA, 16'h0000, "R3 alternating recode");
    apply(8'h01, 8'h01, 16'h7FFF, "R5 wrap up");
    apply(8'hFF, 8'h01, 16'h0000, "R5 wrap down");
    apply(8'h13, 8'h00, 16'h1234, "R4 zero product");
  endtask

  task automatic t_latency();
    logic [15:0] prev;
    apply(8'h03, 8'h04, 16'h0010, "R6 base");
    prev = res_o;
    @(negedge clk);
    op_a_i = 8'h05; coef_i = 8'h06; acc_i = 16'h0100; en_i = 1'b1;
    #1; chk(res_o, prev, "R6 not before edge");
    @(posedge clk); #1;
    chk(res_o, 16'h011E, "R6 after edge");
  endtask

  task automatic t_hold();
    logic [15:0] held;
    apply(8'h11, 8'h22, 16'h0000, "R7 load");
    held = res_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      en_i = 1'b0; op_a_i = 8'(k * 37 + 1); coef_i = 8'(k * 91 + 3); acc_i = 16'(k * 999);
      @(posedge clk); #1;
      chk(res_o, held, "R7 hold");
    end
  endtask

  task automatic t_reset_vs_en();
    apply(8'h7F, 8'h7F, 16'h1111, "R8 preload");
    @(negedge clk);
    op_a_i = 8'h40; coef_i = 8'h40; acc_i = 16'h0101; en_i = 1'b1;
    #2; rst_ni = 1'b0;
    #1; chk(res_o, 16'h0000, "R8 async clear");
    @(posedge clk); #1;
    chk(res_o, 16'h0000, "R8 reset beats enable");
    @(negedge clk); rst_ni = 1'b1;
    apply(8'h40, 8'h40, 16'h0101, "R8 reload after release");
  endtask

  initial begin
    t_reset();
    t_corners();
    t_latency();
    t_hold();
    t_reset_vs_en();
    t_sweep(0);
    t_sweep(1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule